// File: doc/BRIEF.md
# Interrupt Mask Set/Clear Unit

This block keeps a 32-bit interrupt mask and drives a level-sensitive legacy interrupt pin from it. Software never writes the mask directly. One register alias turns mask bits on, a second alias turns them off, and a read of either alias returns the current mask. The pin goes high when a pending status bit has its mask bit clear.

A host that has switched to message-signalled interrupts drives `msg_irq_on` high. While that input is high the pin stays low. Mask writes made in that state still take effect, and each one raises a one-cycle `guest_err` pulse so that surrounding logic can record the misuse. The register port is a simple single-cycle write/read bus. Reads are combinational. Writes take effect at the clock edge.

Top module: `irq_mask_unit`

## Requirements
- R1: An aligned write to byte offset 0x0C ORs `bus_wdata` into the mask; the new mask is visible on `mask_out` after that clock edge.
- R2: An aligned write to byte offset 0x10 clears every mask bit that is 1 in `bus_wdata`; the other mask bits are unchanged.
- R3: A read at offset 0x0C and a read at offset 0x10 both return the current mask on `bus_rdata`, so both show the result of the most recent write.
- R4: `irq_pin` is a registered output. At each clock edge it takes the value 1 when some bit is 1 in `status_in` and 0 in the mask, and 0 otherwise. A mask change therefore shows on the pin one cycle after it shows on `mask_out`.
- R5: While `msg_irq_on` is 1, `irq_pin` is 0 from the next clock edge onward, whatever the status and mask.
- R6: Mask writes accepted while `msg_irq_on` is 1 still update the mask. `guest_err` is 1 for exactly the cycle after each such write and 0 otherwise.
- R7: Reset (active-low `rst_n`) clears the mask, `irq_pin` and `guest_err` to 0.
- R8: A write whose address has a nonzero value in bits [1:0], or whose address is neither 0x0C nor 0x10, leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (mask at the aliases, else 0) |
| status_in | input | 32 | Pending interrupt status bits |
| msg_irq_on | input | 1 | Message-signalled interrupts are enabled |
| irq_pin | output | 1 | Level-sensitive interrupt line |
| mask_out | output | 32 | Current mask |
| guest_err | output | 1 | Pulse after a mask write made while message-signalled interrupts are on |

## Verification
The bench checks that a set write leaves bits already in the mask set, and that a clear write leaves bits not named in the data untouched. A design that wrote the mask directly would fail both. It applies writes at offsets one byte above an alias and at a neighbouring word, which catches a decoder that ignores the low address bits or matches too loosely. It checks the pin two edges after a mask change. It also checks that the pin stays low while message-signalled interrupts are on, even when a write unmasks a pending bit, which catches a design that does not suppress the pin. It checks that such writes are still stored and flagged, which catches a design that drops them.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SET  = 2'd1,
        ACC_CLR  = 2'd2
    } acc_kind_t;
endpackage

// File: rtl/irqm_decode.sv
module irqm_decode
    import irqm_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned SET_OFS = 12,
    parameter int unsigned CLR_OFS = 16
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_t         wr_kind,
    output logic              rd_hit
);
    localparam int unsigned ALIGN_BITS = $clog2(DATA_W / 8);

    logic aligned;
    logic hit_set;
    logic hit_clr;

    always_comb begin
        aligned = (addr[ALIGN_BITS-1:0] == '0);
        hit_set = aligned && (addr == ADDR_W'(SET_OFS));
        hit_clr = aligned && (addr == ADDR_W'(CLR_OFS));
        rd_hit  = rd_en && (hit_set || hit_clr);
        if (wr_en && hit_set)
            wr_kind = ACC_SET;
        else if (wr_en && hit_clr)
            wr_kind = ACC_CLR;
        else
            wr_kind = ACC_NONE;
    end
endmodule

// File: rtl/irqm_mask_reg.sv
module irqm_mask_reg
    import irqm_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_kind_t         wr_kind,
    input  logic [DATA_W-1:0] wdata,
    input  logic              msg_irq_on,
    output logic [DATA_W-1:0] mask,
    output logic              err
);
    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic              err;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        case (wr_kind)
            ACC_SET: st_d.mask = st_q.mask | wdata;
            ACC_CLR: st_d.mask = st_q.mask & ~wdata;
            default: st_d.mask = st_q.mask;
        endcase
        if (wr_kind != ACC_NONE && msg_irq_on)
            st_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign mask = st_q.mask;
    assign err  = st_q.err;

    AST_SET_OR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind == ACC_SET) |=> ((mask & $past(wdata)) == $past(wdata))); // R1
    AST_CLR_ANDN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind == ACC_CLR) |=> ((mask & $past(wdata)) == '0)); // R2
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_kind == ACC_NONE) |=> $stable(mask)); // R8
endmodule

// File: rtl/irqm_pin.sv
module irqm_pin #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] mask,
    input  logic              msg_irq_on,
    output logic              irq
);
    logic [DATA_W-1:0] pend;
    logic              irq_d, irq_q;

    for (genvar i = 0; i < DATA_W; i++) begin : g_pend
        assign pend[i] = status[i] & ~mask[i];
    end

    always_comb begin
        irq_d = (|pend) && !msg_irq_on;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= irq_d;
    end

    assign irq = irq_q;

    AST_PIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_irq_on && ((status & ~mask) != '0)) |=> irq); // R4
    AST_PIN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~mask) == '0) |=> !irq); // R4
    AST_MSI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        msg_irq_on |=> !irq); // R5
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
    import irqm_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned SET_OFS = 12,
    parameter int unsigned CLR_OFS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] status_in,
    input  logic              msg_irq_on,
    output logic              irq_pin,
    output logic [DATA_W-1:0] mask_out,
    output logic              guest_err
);
    acc_kind_t         wr_kind;
    logic              rd_hit;
    logic [DATA_W-1:0] mask_q;

    irqm_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SET_OFS(SET_OFS),
        .CLR_OFS(CLR_OFS)
    ) i_decode (
        .wr_en  (bus_wr_en),
        .rd_en  (bus_rd_en),
        .addr   (bus_addr),
        .wr_kind(wr_kind),
        .rd_hit (rd_hit)
    );

    irqm_mask_reg #(.DATA_W(DATA_W)) i_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_kind   (wr_kind),
        .wdata     (bus_wdata),
        .msg_irq_on(msg_irq_on),
        .mask      (mask_q),
        .err       (guest_err)
    );

    irqm_pin #(.DATA_W(DATA_W)) i_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .status    (status_in),
        .mask      (mask_q),
        .msg_irq_on(msg_irq_on),
        .irq       (irq_pin)
    );

    assign bus_rdata = rd_hit ? mask_q : '0;
    assign mask_out  = mask_q;

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        guest_err |-> $past(msg_irq_on && (wr_kind != ACC_NONE))); // R6
    AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_irq_on && (wr_kind != ACC_NONE)) |=> guest_err); // R6
endmodule

// File: tb/test_irq_mask_unit.sv
`timescale 1ns/1ps
module test_irq_mask_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] status_in = '0;
    logic        msg_irq_on = 1'b0;
    logic        irq_pin;
    logic [31:0] mask_out;
    logic        guest_err;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    irq_mask_unit i_irq_mask_unit (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .status_in(status_in), .msg_irq_on(msg_irq_on), .irq_pin(irq_pin),
        .mask_out(mask_out), .guest_err(guest_err)
    );

    // op[108:107] addr[106:99] data[98:67] status[66:35] msi[34] mask[33:2] pin[1] err[0]
    localparam int NV = 14;
    localparam logic [108:0] VEC [NV] = '{
        {2'd1, 8'h0C, 32'hFFFF0000, 32'h00000000, 1'b0, 32'hFFFF0000, 1'b0, 1'b0}, // R1
        {2'd1, 8'h10, 32'h0F000000, 32'h00000000, 1'b0, 32'hF0FF0000, 1'b0, 1'b0}, // R2
        {2'd0, 8'h00, 32'h00000000, 32'h00000001, 1'b0, 32'hF0FF0000, 1'b1, 1'b0}, // R4
        {2'd1, 8'h0C, 32'h00000001, 32'h00000001, 1'b0, 32'hF0FF0001, 1'b0, 1'b0}, // R1 R4
        {2'd0, 8'h00, 32'h00000000, 32'h80000000, 1'b0, 32'hF0FF0001, 1'b0, 1'b0}, // R4
        {2'd0, 8'h00, 32'h00000000, 32'h01000000, 1'b0, 32'hF0FF0001, 1'b1, 1'b0}, // R4
        {2'd1, 8'h0D, 32'h01000000, 32'h01000000, 1'b0, 32'hF0FF0001, 1'b1, 1'b0}, // R8
        {2'd1, 8'h14, 32'h01000000, 32'h01000000, 1'b0, 32'hF0FF0001, 1'b1, 1'b0}, // R8
        {2'd0, 8'h00, 32'h00000000, 32'h01000000, 1'b1, 32'hF0FF0001, 1'b0, 1'b0}, // R5
        {2'd1, 8'h0C, 32'h01000000, 32'h01000000, 1'b1, 32'hF1FF0001, 1'b0, 1'b1}, // R6
        {2'd1, 8'h10, 32'hFFFFFFFF, 32'h01000000, 1'b1, 32'h00000000, 1'b0, 1'b1}, // R6 R5
        {2'd0, 8'h00, 32'h00000000, 32'h00000010, 1'b0, 32'h00000000, 1'b1, 1'b0}, // R4
        {2'd1, 8'h0C, 32'h00000010, 32'h00000010, 1'b0, 32'h00000010, 1'b0, 1'b0}, // R1
        {2'd1, 8'h0E, 32'hFFFFFFFF, 32'h00000010, 1'b0, 32'h00000010, 1'b0, 1'b0}  // R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_alias(input logic [7:0] a, input logic [31:0] exp);
        bus_rd_en = 1'b1;
        bus_addr  = a;
        #1;
        check("R3 alias readback", bus_rdata, exp);
        bus_rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        check("R7 mask at reset", mask_out, 32'h0);
        check("R7 pin at reset", {31'h0, irq_pin}, 32'h0);
        check("R7 err at reset", {31'h0, guest_err}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [108:0] v;
            v = VEC[i];
            bus_addr   = v[106:99];
            bus_wdata  = v[98:67];
            status_in  = v[66:35];
            msg_irq_on = v[34];
            bus_wr_en  = (v[108:107] == 2'd1);
            @(negedge clk);
            bus_wr_en = 1'b0;
            check("R1 R2 R8 mask after write", mask_out, v[33:2]);
            check("R6 guest_err pulse", {31'h0, guest_err}, {31'h0, v[0]});
            read_alias(8'h0C, v[33:2]);
            read_alias(8'h10, v[33:2]);
            @(negedge clk);
            check("R4 R5 pin level", {31'h0, irq_pin}, {31'h0, v[1]});
            check("R6 guest_err one cycle", {31'h0, guest_err}, 32'h0);
        end

        // R7: reset mid-run with pending unmasked status
        bus_wdata = 32'h0000FF00; bus_addr = 8'h0C; bus_wr_en = 1'b1;
        status_in = 32'h00000001; msg_irq_on = 1'b0;
        @(negedge clk);
        bus_wr_en = 1'b0;
        @(negedge clk);
        check("R4 pin before reset", {31'h0, irq_pin}, 32'h1);
        rst_n = 1'b0;
        #1;
        check("R7 mask cleared", mask_out, 32'h0);
        check("R7 pin cleared", {31'h0, irq_pin}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        status_in = 32'h0;
        @(negedge clk);
        read_alias(8'h10, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule